// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block is the per-core monitor behind load-exclusive / store-exclusive pairs aimed at non-shareable memory. A load-exclusive remembers the naturally aligned granule that holds its address and moves the monitor from the open state to the exclusive state. A later store-exclusive is allowed to write memory only if the monitor is still exclusive and the store address lies inside that remembered granule.

The store-exclusive reports a status bit one cycle after the request: 0 for success, 1 for failure. In that same cycle the block drives the memory write strobe, and only on success. Every store-exclusive sends the monitor back to the open state, whatever its outcome. A clear input, which the core also pulses on exception entry, drops any reservation.

The granule is `2**GRAN_LOG2` bytes, with `GRAN_LOG2` from 4 to 11. The granule is found by clearing the low `GRAN_LOG2` address bits, so it is a region match and not an exact address compare.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the monitor is open, `stx_done_o` and `mem_we_o` are 0, and a store-exclusive with no prior load-exclusive fails.
- R2: A load-exclusive records the base `ldx_addr_i & ~(2**GRAN_LOG2-1)` and makes the monitor exclusive. With `GRAN_LOG2`=4, address 0x341B4 marks 0x341B0 to 0x341BF.
- R3: A store-exclusive to any address in the marked granule while the monitor is exclusive succeeds. It gives `stx_fail_o`=0 and `mem_we_o`=1, with `mem_addr_o` and `mem_data_o` equal to the request's address and data.
- R4: A store-exclusive in the open state, or outside the marked granule, fails. It gives `stx_fail_o`=1 and `mem_we_o`=0.
- R5: Every store-exclusive, whether it succeeds or fails, leaves the monitor open, so a second store-exclusive without a new load-exclusive fails.
- R6: A load-exclusive while the monitor is already exclusive replaces the marked granule. Stores to the old granule then fail.
- R7: `clrex_i` forces the open state for the next cycle. This holds even when a load-exclusive arrives in the same cycle. A store-exclusive in the same cycle as `clrex_i` is judged on the state before the clear.
- R8: When a load-exclusive and a store-exclusive arrive together, the store is judged on the prior reservation. The monitor then holds the new granule as exclusive.
- R9: `stx_done_o` is 1 exactly one cycle after each store-exclusive request and 0 in every other cycle.
- R10: Granule edges are exact. The first and last byte of the marked granule succeed, and the first byte of the next granule fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ldx_req_i | input | 1 | Load-exclusive request |
| ldx_addr_i | input | ADDR_W | Load-exclusive byte address |
| stx_req_i | input | 1 | Store-exclusive request |
| stx_addr_i | input | ADDR_W | Store-exclusive byte address |
| stx_data_i | input | DATA_W | Store-exclusive write data |
| clrex_i | input | 1 | Clear reservation (clear-exclusive or exception entry) |
| stx_done_o | output | 1 | Store-exclusive status valid |
| stx_fail_o | output | 1 | Status: 0 success, 1 failure |
| mem_we_o | output | 1 | Memory write strobe, success only |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |

## Verification
The hardest cases are the same-cycle collisions. One is a store-exclusive arriving together with a new load-exclusive. The other is a store-exclusive arriving together with a clear. In both, the store's result and the state left behind come from different points in time. The driver task sets any mix of the three request lines in one cycle to reach these cases. The scoreboard then expects the prior reservation's outcome for the store and checks the new state with a follow-up store. Granule edges are reached by aiming stores at the first byte, the last byte and the byte just past a 16-byte granule.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;

  localparam int unsigned GRAN_LOG2_MIN = 4;
  localparam int unsigned GRAN_LOG2_MAX = 11;
endpackage

// File: rtl/excl_mon_granule.sv
module excl_mon_granule #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] ldx_addr_i,
  input  logic [ADDR_W-1:0] stx_addr_i,
  input  logic [ADDR_W-1:0] mark_base_i,
  output logic [ADDR_W-1:0] ldx_base_o,
  output logic              stx_hit_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN_LOG2) - 64'd1);

  // Clear the offset bits inside the granule
  function automatic logic [ADDR_W-1:0] base_of(input logic [ADDR_W-1:0] a);
    return a & ~LOW_MASK;
  endfunction

  logic [ADDR_W-1:0] stx_base;

  assign ldx_base_o = base_of(ldx_addr_i);
  assign stx_base   = base_of(stx_addr_i);
  assign stx_hit_o  = (stx_base == mark_base_i);
endmodule

// File: rtl/excl_mon_fsm.sv
module excl_mon_fsm
  import excl_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldx_i,
  input  logic [ADDR_W-1:0] ldx_base_i,
  input  logic              stx_i,
  input  logic              clr_i,
  output mon_state_e        state_o,
  output logic [ADDR_W-1:0] base_o
);
  mon_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;

  // Priority: clear, then load-exclusive, then store-exclusive
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    if (clr_i) begin
      state_d = MON_OPEN;
    end else if (ldx_i) begin
      state_d = MON_EXCL;
      base_d  = ldx_base_i;
    end else if (stx_i) begin
      state_d = MON_OPEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_OPEN;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
    end
  end

  assign state_o = state_q;
  assign base_o  = base_q;

  p_clear_opens_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> state_q == MON_OPEN);
  p_ldx_marks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldx_i && !clr_i) |=> (state_q == MON_EXCL) && (base_q == $past(ldx_base_i)));
  p_stx_opens_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && !ldx_i) |=> state_q == MON_OPEN);
  p_idle_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stx_i && !ldx_i && !clr_i) |=> $stable(state_q) && $stable(base_q));
endmodule

// File: rtl/excl_mon_resp.sv
module excl_mon_resp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stx_i,
  input  logic              pass_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              done_q, fail_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done_q <= stx_i;
      if (stx_i) begin
        fail_q <= ~pass_i;
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign done_o = done_q;
  assign fail_o = fail_q;
  assign we_o   = done_q & ~fail_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  p_done_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> done_o);
  p_no_spurious_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stx_i |=> !done_o && !we_o);
  p_pass_writes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && pass_i) |=> we_o && !fail_o && (addr_o == $past(addr_i)));
  p_fail_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && !pass_i) |=> fail_o && !we_o);
endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned GRAN_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldx_req_i,
  input  logic [ADDR_W-1:0] ldx_addr_i,
  input  logic              stx_req_i,
  input  logic [ADDR_W-1:0] stx_addr_i,
  input  logic [DATA_W-1:0] stx_data_i,
  input  logic              clrex_i,
  output logic              stx_done_o,
  output logic              stx_fail_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  if (GRAN_LOG2 < GRAN_LOG2_MIN || GRAN_LOG2 > GRAN_LOG2_MAX) begin : g_bad_gran
    $error("GRAN_LOG2 out of supported range");
  end

  mon_state_e        mon_state;
  logic [ADDR_W-1:0] mark_base;
  logic [ADDR_W-1:0] ldx_base;
  logic              stx_hit;
  logic              stx_pass;

  excl_mon_granule #(
    .ADDR_W   (ADDR_W),
    .GRAN_LOG2(GRAN_LOG2)
  ) i_granule (
    .ldx_addr_i (ldx_addr_i),
    .stx_addr_i (stx_addr_i),
    .mark_base_i(mark_base),
    .ldx_base_o (ldx_base),
    .stx_hit_o  (stx_hit)
  );

  excl_mon_fsm #(
    .ADDR_W(ADDR_W)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ldx_i     (ldx_req_i),
    .ldx_base_i(ldx_base),
    .stx_i     (stx_req_i),
    .clr_i     (clrex_i),
    .state_o   (mon_state),
    .base_o    (mark_base)
  );

  // Judged on the state held before this cycle's requests
  assign stx_pass = (mon_state == MON_EXCL) && stx_hit;

  excl_mon_resp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_resp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stx_i (stx_req_i),
    .pass_i(stx_pass),
    .addr_i(stx_addr_i),
    .data_i(stx_data_i),
    .done_o(stx_done_o),
    .fail_o(stx_fail_o),
    .we_o  (mem_we_o),
    .addr_o(mem_addr_o),
    .data_o(mem_data_o)
  );

  p_open_store_fails_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_req_i && mon_state == MON_OPEN) |=> stx_fail_o);
  p_new_mark_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldx_req_i && stx_req_i && !clrex_i) |=> mon_state == MON_EXCL);
endmodule

// File: tb/test_excl_mon_top.sv
module test_excl_mon_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ldx_req = 1'b0, stx_req = 1'b0, clrex = 1'b0;
  logic [AW-1:0] ldx_addr = '0, stx_addr = '0;
  logic [DW-1:0] stx_data = '0;
  logic          done, fail, we;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int            when;
    bit            fail;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  excl_mon_top #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LOG2(4)) i_excl_mon_top (
    .clk_i(clk), .rst_ni(rst_n),
    .ldx_req_i(ldx_req), .ldx_addr_i(ldx_addr),
    .stx_req_i(stx_req), .stx_addr_i(stx_addr), .stx_data_i(stx_data),
    .clrex_i(clrex),
    .stx_done_o(done), .stx_fail_o(fail), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_data_o(mdata)
  );

  function automatic logic [DW-1:0] dat_of(logic [AW-1:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  // One cycle of stimulus, driven at the falling edge
  task automatic op(bit l, logic [AW-1:0] la, bit s, logic [AW-1:0] sa, bit c,
                    bit exp_fail, string req);
    exp_t e;
    ldx_req = l; ldx_addr = la;
    stx_req = s; stx_addr = sa; stx_data = dat_of(sa);
    clrex = c;
    if (s) begin
      e.when = cyc + 1; e.fail = exp_fail; e.addr = sa; e.data = dat_of(sa); e.req = req;
      sb.push_back(e);
    end
    @(negedge clk);
    ldx_req = 0; stx_req = 0; clrex = 0;
  endtask

  task automatic ldx(logic [AW-1:0] a);
    op(1, a, 0, '0, 0, 0, "");
  endtask

  task automatic stx(logic [AW-1:0] a, bit exp_fail, string req);
    op(0, '0, 1, a, 0, exp_fail, req);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (done) begin
          exp_t e;
          checks++;
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R9: done=1 with no request pending (act 1 exp 0)");
          end else begin
            e = sb.pop_front();
            if (e.when != cyc) begin
              errors++;
              $display("FAIL R9: status at cycle %0d exp %0d", cyc, e.when);
            end
            if (fail !== e.fail || we !== !e.fail) begin
              errors++;
              $display("FAIL %s: addr %h fail=%0d we=%0d exp fail=%0d we=%0d",
                       e.req, e.addr, fail, we, e.fail, !e.fail);
            end else if (!e.fail && (maddr !== e.addr || mdata !== e.data)) begin
              errors++;
              $display("FAIL %s: mem addr/data %h/%h exp %h/%h",
                       e.req, maddr, mdata, e.addr, e.data);
            end
          end
        end else if (we) begin
          checks++;
          errors++;
          $display("FAIL R9: mem_we_o=1 without done (act 1 exp 0)");
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung (act running exp finished)");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (done !== 1'b0 || we !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset done=%0d we=%0d exp 0 0", done, we);
    end
    rst_n = 1'b1;
    @(negedge clk);
    stx(32'h0000_0040, 1, "R1");
    repeat (2) @(negedge clk);

    // R2 R3 R10: mark 0x341B4, granule 0x341B0..0x341BF
    ldx(32'h0003_41B4);
    stx(32'h0003_41BF, 0, "R10");
    ldx(32'h0003_41B4);
    stx(32'h0003_41B0, 0, "R2");
    ldx(32'h0003_41B4);
    stx(32'h0003_41B4, 0, "R3");
    // R5 second store without new mark
    stx(32'h0003_41B4, 1, "R5");
    // R10 next granule fails, R5 failed store still opens
    ldx(32'h0003_41B4);
    stx(32'h0003_41C0, 1, "R10");
    stx(32'h0003_41B8, 1, "R5");
    repeat (3) @(negedge clk);

    // R6 re-mark replaces granule
    ldx(32'h0000_1000);
    ldx(32'h0000_2008);
    stx(32'h0000_1004, 1, "R6");
    ldx(32'h0000_1000);
    ldx(32'h0000_2008);
    stx(32'h0000_200C, 0, "R6");

    // R7 clear
    ldx(32'h0000_0500);
    op(0, '0, 0, '0, 1, 0, "");
    stx(32'h0000_0500, 1, "R7");
    ldx(32'h0000_0500);
    op(0, '0, 1, 32'h0000_0508, 1, 0, "R7");   // store judged before clear
    op(1, 32'h0000_0600, 0, '0, 1, 0, "");      // clear beats mark
    stx(32'h0000_0600, 1, "R7");

    // R8 mark and store in same cycle
    ldx(32'h0000_0700);
    op(1, 32'h0000_0900, 1, 32'h0000_0704, 0, 0, "R8");
    stx(32'h0000_0904, 0, "R8");
    op(1, 32'h0000_0A00, 1, 32'h0000_0A00, 0, 1, "R8"); // open before: fail
    stx(32'h0000_0A0F, 0, "R8");

    // R4 open state, idle gaps for R9
    repeat (4) @(negedge clk);
    stx(32'h0000_0A00, 1, "R4");
    repeat (4) @(negedge clk);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing (exp 0)", sb.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule